// File: doc/BRIEF.md
# Flow-Through FIFO with Holding Latch

This block is a sixteen-entry synchronous FIFO with no output register. The data output is wired straight from the array slot that the last accepted read consumed. A word read out therefore stays visible only while nothing overwrites that slot. Starting from empty, the write that fills the FIFO lands in exactly that slot, so the visible output changes on that write even though no read took place.

Two guards are provided against this. The first is a holding register with its own load control, plus a select input that routes either the raw array output or the held word to the output pin. The second is an early-full mode. In that mode, writes are refused once fifteen words are stored, so the filling write never happens and the last-read slot is never overwritten.

Top module: `flowthru_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, early_full is 0, and data_out is 0 with either setting of out_sel, because the array and the holding register both clear to zero.
- R2: Words leave in the order they were accepted. After an accepted read, data_out with out_sel=0 shows the word just read, and it keeps showing it until the next accepted read, unless the case in R5 occurs.
- R3: full is 1 exactly when sixteen words are stored. A write request while full is refused and changes neither the stored words nor the flags. full and empty are never both 1.
- R4: empty is 1 exactly when no words are stored. A read request while empty is refused, and data_out with out_sel=0 does not change.
- R5: With early_mode=0, the sixteenth net write after the FIFO is empty writes into the slot last read, so data_out with out_sel=0 changes to that newly written word in the same cycle that full rises.
- R6: A read and a write in the same cycle are both accepted when neither flag blocks them, and the occupancy then stays the same. When full, only the read is taken. When empty, only the write is taken.
- R7: With early_mode=1, early_full is 1 exactly when fifteen words are stored, and writes are refused while it is 1. full never rises and data_out with out_sel=0 is left untouched. With early_mode=0, early_full stays 0.
- R8: On a clock edge where hold_load=1, the holding register captures the raw array output present before that edge. Otherwise it keeps its value. With out_sel=1 (select code 1), data_out shows the holding register.
- R9: With out_sel=0 (select code 0), data_out shows the raw array output in the same cycle, with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| early_mode | input | 1 | 1 refuses writes at fifteen stored words |
| push | input | 1 | Write request |
| push_data | input | WIDTH | Word to write |
| pop | input | 1 | Read request |
| hold_load | input | 1 | Load the holding register from the raw output |
| out_sel | input | 1 | 0 selects raw array output, 1 selects held word |
| data_out | output | WIDTH | Selected output word |
| full | output | 1 | Sixteen words stored |
| empty | output | 1 | No words stored |
| early_full | output | 1 | Fifteen words stored while early_mode is 1 |

## Verification
The bench builds the block with its default parameters: sixteen entries of eight bits. That size is small enough to drive the FIFO from empty to full and back in a handful of cycles. Every pointer wrap and both fill limits are therefore reached many times, in both early_mode settings. A long pseudo-random sweep over every combination of push, pop, load and select compares all outputs each cycle against an arithmetic model. Directed runs cover the filling-write overwrite, the early-full throttle and the holding register protecting the output.

// File: rtl/flowthru_pkg.sv
package flowthru_pkg;
    localparam int unsigned FT_DEPTH_DEF = 16;
    localparam int unsigned FT_WIDTH_DEF = 8;

    typedef enum logic {
        SRC_RAW  = 1'b0,
        SRC_HOLD = 1'b1
    } out_src_e;
endpackage

// File: rtl/flowthru_ctrl.sv
module flowthru_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          early_mode,
    input  logic          push,
    input  logic          pop,
    output logic          wr_ok,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic          full,
    output logic          empty,
    output logic          early_full
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  rd_ok;

    always_comb begin
        full       = (st_q.cnt == CW'(DEPTH));
        empty      = (st_q.cnt == '0);
        early_full = early_mode && (st_q.cnt == CW'(DEPTH - 1));
        wr_ok      = push && !full && !early_full;
        rd_ok      = pop && !empty;
        st_d       = st_q;
        if (wr_ok) st_d.wp = st_q.wp + PW'(1);
        if (rd_ok) st_d.rp = st_q.rp + PW'(1);
        unique case ({wr_ok, rd_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_idx = st_q.wp;
    assign rd_idx = st_q.rp;
endmodule

// File: rtl/flowthru_array.sv
module flowthru_array #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [PW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [PW-1:0]    rd_idx,
    output logic [WIDTH-1:0] raw_word
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    last_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_ok && (wr_idx == PW'(g))) mem_d[g] = wr_word;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    // The output is the slot just behind the read pointer: the one last consumed.
    assign last_idx = rd_idx - PW'(1);
    assign raw_word = mem_q[last_idx];
endmodule

// File: rtl/flowthru_hold.sv
module flowthru_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sel,
    input  logic [WIDTH-1:0] raw_word,
    output logic [WIDTH-1:0] out_word
);
    import flowthru_pkg::*;

    logic [WIDTH-1:0] hold_d, hold_q;
    out_src_e         src;

    always_comb begin
        hold_d = load ? raw_word : hold_q;
        src    = out_src_e'(sel);
        out_word = (src == SRC_HOLD) ? hold_q : raw_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/flowthru_fifo.sv
module flowthru_fifo #(
    parameter int unsigned DEPTH = flowthru_pkg::FT_DEPTH_DEF,
    parameter int unsigned WIDTH = flowthru_pkg::FT_WIDTH_DEF,
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             early_mode,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             hold_load,
    input  logic             out_sel,
    output logic [WIDTH-1:0] data_out,
    output logic             full,
    output logic             empty,
    output logic             early_full
);
    logic             wr_ok;
    logic [PW-1:0]    wr_idx;
    logic [PW-1:0]    rd_idx;
    logic [WIDTH-1:0] raw_word;

    flowthru_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .early_mode (early_mode),
        .push       (push),
        .pop        (pop),
        .wr_ok      (wr_ok),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .full       (full),
        .empty      (empty),
        .early_full (early_full)
    );

    flowthru_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wr_idx   (wr_idx),
        .wr_word  (push_data),
        .rd_idx   (rd_idx),
        .raw_word (raw_word)
    );

    flowthru_hold #(.WIDTH(WIDTH)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .sel      (out_sel),
        .raw_word (raw_word),
        .out_word (data_out)
    );
endmodule

// File: rtl/flowthru_fifo_chk.sv
module flowthru_fifo_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             early_mode,
    input logic             push,
    input logic             pop,
    input logic             hold_load,
    input logic             out_sel,
    input logic [WIDTH-1:0] data_out,
    input logic             full,
    input logic             empty,
    input logic             early_full
);
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full);

    assert_empty_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !out_sel |=> (out_sel || data_out == $past(data_out)));

    assert_early_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        early_full && !pop |=> !full);

    assert_early_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        early_full |-> early_mode);

    assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel && !hold_load |=> (!out_sel || data_out == $past(data_out)));

    assert_hold_captures_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_load && !out_sel |=> (!out_sel || data_out == $past(data_out)));
endmodule

bind flowthru_fifo flowthru_fifo_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_mode (early_mode),
    .push       (push),
    .pop        (pop),
    .hold_load  (hold_load),
    .out_sel    (out_sel),
    .data_out   (data_out),
    .full       (full),
    .empty      (empty),
    .early_full (early_full)
);

// File: tb/test_flowthru_fifo.sv
module test_flowthru_fifo;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             early_mode = 1'b0;
    logic             push = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic             pop = 1'b0;
    logic             hold_load = 1'b0;
    logic             out_sel = 1'b0;
    logic [WIDTH-1:0] data_out;
    logic             full, empty, early_full;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model
    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [3:0]       m_wp, m_rp;
    int               m_cnt;
    logic [WIDTH-1:0] m_hold;

    always #4 clk = ~clk;   // 125 MHz

    flowthru_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_flowthru_fifo (
        .clk(clk), .rst_n(rst_n), .early_mode(early_mode), .push(push),
        .push_data(push_data), .pop(pop), .hold_load(hold_load), .out_sel(out_sel),
        .data_out(data_out), .full(full), .empty(empty), .early_full(early_full)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] m_raw();
        return m_mem[m_rp - 4'd1];
    endfunction

    task automatic compare_all(input string tag);
        chk(tag, "empty (R4)", int'(empty), int'(m_cnt == 0));
        chk(tag, "full (R3)", int'(full), int'(m_cnt == DEPTH));
        chk(tag, "early_full (R7)", int'(early_full), int'(early_mode && m_cnt == DEPTH - 1));
        chk(tag, "data_out", int'(data_out), int'(out_sel ? m_hold : m_raw()));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; push = 0; pop = 0; hold_load = 0; out_sel = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_wp = '0; m_rp = '0; m_cnt = 0; m_hold = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc(input logic w, input logic [WIDTH-1:0] d, input logic r,
                       input logic ld, input logic sel, input string tag);
        logic wa, ra;
        logic [WIDTH-1:0] raw_pre;
        push = w; push_data = d; pop = r; hold_load = ld; out_sel = sel;
        @(posedge clk);
        raw_pre = m_raw();
        wa = w && (m_cnt != DEPTH) && !(early_mode && m_cnt == DEPTH - 1);
        ra = r && (m_cnt != 0);
        if (wa) begin m_mem[m_wp] = d; m_wp = m_wp + 4'd1; m_cnt++; end
        if (ra) begin m_rp = m_rp + 4'd1; m_cnt--; end
        if (ld) m_hold = raw_pre;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "early_full", int'(early_full), 0);
        chk("R1", "data_out raw", int'(data_out), 0);
        out_sel = 1'b1; #1;
        chk("R1", "data_out held", int'(data_out), 0);
        out_sel = 1'b0;

        // R4: reads on empty are refused
        repeat (3) cyc(0, 8'h00, 1, 0, 0, "R4");

        // R5: filling write overwrites the last-read slot
        cyc(1, 8'hAA, 0, 0, 0, "R2");
        cyc(0, 8'h00, 1, 0, 0, "R2");
        chk("R2", "first read word", int'(data_out), 'hAA);
        for (int i = 1; i <= 15; i++) cyc(1, 8'hB0 + 8'(i), 0, 0, 0, "R5");
        chk("R5", "output before fill", int'(data_out), 'hAA);
        chk("R5", "not yet full", int'(full), 0);
        cyc(1, 8'h5C, 0, 0, 0, "R5");
        chk("R5", "output after fill", int'(data_out), 'h5C);
        chk("R5", "full after fill", int'(full), 1);

        // R3: writes while full are refused
        repeat (3) cyc(1, 8'hEE, 0, 0, 0, "R3");
        // R6: read+write on full takes only the read
        cyc(1, 8'hEF, 1, 0, 0, "R6");
        chk("R6", "full drops", int'(full), 0);
        // R6: steady read+write keeps occupancy
        for (int i = 0; i < 20; i++) cyc(1, 8'h40 + 8'(i), 1, 0, 0, "R6");
        // R2: drain in order
        for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1, 0, 0, "R2");
        chk("R2", "drained empty", int'(empty), 1);
        // R6: read+write on empty takes only the write
        cyc(1, 8'h77, 1, 0, 0, "R6");
        chk("R6", "one stored", int'(empty), 0);

        // R7: early-full throttle
        do_reset();
        early_mode = 1'b1;
        @(negedge clk);
        cyc(1, 8'hAA, 0, 0, 0, "R7");
        cyc(0, 8'h00, 1, 0, 0, "R7");
        for (int i = 0; i < 20; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, "R7");
        chk("R7", "early_full set", int'(early_full), 1);
        chk("R7", "full never", int'(full), 0);
        chk("R7", "output kept", int'(data_out), 'hAA);
        for (int i = 0; i < DEPTH - 1; i++) cyc(0, 8'h00, 1, 0, 0, "R7");
        chk("R7", "drained", int'(empty), 1);
        early_mode = 1'b0;

        // R8/R9: holding register protects the output
        do_reset();
        @(negedge clk);
        cyc(1, 8'h11, 0, 0, 0, "R8");
        cyc(0, 8'h00, 1, 0, 0, "R8");
        cyc(0, 8'h00, 0, 1, 1, "R8");
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'h80 + 8'(i), 0, 0, 1, "R8");
        chk("R8", "held word", int'(data_out), 'h11);
        out_sel = 1'b0; #1;
        chk("R9", "raw after overwrite", int'(data_out), 'h8F);

        // Sweep: pseudo-random traffic in both modes
        for (int mode = 0; mode < 2; mode++) begin
            do_reset();
            early_mode = mode[0];
            @(negedge clk);
            lfsr = 16'hACE1 ^ 16'(mode);
            for (int i = 0; i < 4000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & lfsr[6], lfsr[2] & lfsr[3],
                    lfsr[4], mode == 0 ? "R2 sweep" : "R7 sweep");
            end
        end
        early_mode = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule